// File: doc/BRIEF.md
# Shadow Write-Through Memory Controller

This controller sits between a processor bus and two memories that answer at the same addresses inside one window. The slow memory is shared with a video fetcher and can stall for any number of cycles. The fast memory is a private synchronous RAM with one cycle of read latency. Inside the window every processor write goes to both memories. The fast copy is written in the cycle the request is accepted. The acknowledge waits for the slow memory's ready, so the fetcher always holds a full copy of what was written. Reads inside the window come from the fast copy only and never touch the slow memory. Addresses outside the window go to the slow memory unchanged.

The processor raises `cpu_req` and holds the address, data, strobes and direction stable until it sees a one-cycle `cpu_ack`. It then drops `cpu_req` in the following cycle. The slow port holds `slow_req` and its fields stable until it samples `slow_ready` high. Read data arrives on `slow_rdata` in that same cycle.

Top module: `shadow_wt_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cpu_ack`, `slow_req` and `fast_en` are low.
- R2: A write accepted inside the window drives `fast_en` and `fast_we` high in the accept cycle. `fast_addr` equals the address minus WIN_BASE, and `fast_wdata` and `fast_be` equal the processor's data and strobes.
- R3: A write inside the window also raises `slow_req` from the cycle after acceptance, with `slow_we` high and the unchanged processor address, data and byte strobes. The slow memory therefore ends up with the same bytes as the fast copy.
- R4: The acknowledge of any access that uses the slow port comes exactly one cycle after the cycle in which `slow_req` and `slow_ready` are both high, and never earlier.
- R5: A read inside the window raises `fast_en` with `fast_we` low in the accept cycle and never raises `slow_req`. `cpu_ack` comes exactly two cycles after acceptance, with `cpu_rdata` equal to the word the fast RAM returned.
- R6: An access outside the window never raises `fast_en`. It goes to the slow port with the processor's address, direction, data and strobes, and a read returns `slow_rdata`.
- R7: `cpu_ack` is high for one cycle per access. While `slow_req` is high and `slow_ready` is low, `slow_req` stays high and its address, direction, data and strobes stay unchanged.
- R8: WIN_BASE and WIN_BASE+WIN_SIZE-1 fall inside the window. WIN_BASE-1 and WIN_BASE+WIN_SIZE fall outside it.
- R9: A read returns the last value written to that address. Byte strobe bit i, where 1 means write, selects data bits 8i+7 down to 8i, and unselected bytes keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte strobes, 1 = byte written |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ack |
| slow_req | output | 1 | Slow memory request |
| slow_we | output | 1 | Slow memory write |
| slow_addr | output | ADDR_W | Slow memory word address |
| slow_wdata | output | DATA_W | Slow memory write data |
| slow_be | output | DATA_W/8 | Slow memory byte strobes |
| slow_ready | input | 1 | Slow memory transfer completes this cycle |
| slow_rdata | input | DATA_W | Slow memory read data, valid with slow_ready |
| fast_en | output | 1 | Fast RAM access enable |
| fast_we | output | 1 | Fast RAM write |
| fast_addr | output | $clog2(WIN_SIZE) | Fast RAM word address (offset into window) |
| fast_wdata | output | DATA_W | Fast RAM write data |
| fast_be | output | DATA_W/8 | Fast RAM byte strobes |
| fast_rdata | input | DATA_W | Fast RAM read data, one cycle after fast_en |

## Verification
A wrong state register makes the acknowledge arrive at the wrong time. It may come early, before the slow ready, or late, beyond the fixed two cycles of a window read. It may also be repeated, and the cycle-by-cycle comparison catches this in the cycle it happens. A wrong window decode or offset shows in the accept cycle itself. It appears as a fast enable on an outside address, a slow request on a window read, or a fast address that is off by the base. Divergence between the two copies stays hidden until the address is read back. The bench therefore rereads a small address set repeatedly, with random strobes and random slow wait states, and compares the slow model's contents against the written history.

// File: rtl/shadow_wt_ctrl.sv
module shadow_wt_ctrl #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int WIN_BASE = 'h10000,
  parameter int WIN_SIZE = 'h10000,
  localparam int BE_W    = DATA_W / 8,
  localparam int FA_W    = $clog2(WIN_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [BE_W-1:0]   cpu_be,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              slow_req,
  output logic              slow_we,
  output logic [ADDR_W-1:0] slow_addr,
  output logic [DATA_W-1:0] slow_wdata,
  output logic [BE_W-1:0]   slow_be,
  input  logic              slow_ready,
  input  logic [DATA_W-1:0] slow_rdata,
  output logic              fast_en,
  output logic              fast_we,
  output logic [FA_W-1:0]   fast_addr,
  output logic [DATA_W-1:0] fast_wdata,
  output logic [BE_W-1:0]   fast_be,
  input  logic [DATA_W-1:0] fast_rdata
);

  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(WIN_BASE + WIN_SIZE);

  typedef enum logic [1:0] {ST_IDLE, ST_FRD, ST_SLOW, ST_DONE} st_t;
  st_t st;

  logic in_win, accept;

  assign in_win = ({1'b0, cpu_addr} >= WIN_LO) && ({1'b0, cpu_addr} < WIN_HI);
  assign accept = (st == ST_IDLE) && cpu_req;

  assign fast_en    = accept && in_win;
  assign fast_we    = cpu_we;
  assign fast_addr  = FA_W'(cpu_addr - WIN_LO[ADDR_W-1:0]);
  assign fast_wdata = cpu_wdata;
  assign fast_be    = cpu_be;

  assign slow_req = (st == ST_SLOW);
  assign cpu_ack  = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      slow_we    <= 1'b0;
      slow_addr  <= '0;
      slow_wdata <= '0;
      slow_be    <= '0;
      cpu_rdata  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (cpu_req) begin
          if (in_win && !cpu_we) begin
            st <= ST_FRD;
          end else begin
            st         <= ST_SLOW;
            slow_we    <= cpu_we;
            slow_addr  <= cpu_addr;
            slow_wdata <= cpu_wdata;
            slow_be    <= cpu_be;
          end
        end
        ST_FRD: begin
          cpu_rdata <= fast_rdata;
          st        <= ST_DONE;
        end
        ST_SLOW: if (slow_ready) begin
          if (!slow_we) cpu_rdata <= slow_rdata;
          st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

module shadow_wt_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ack,
  input logic              slow_req,
  input logic              slow_we,
  input logic [ADDR_W-1:0] slow_addr,
  input logic [DATA_W-1:0] slow_wdata,
  input logic [BE_W-1:0]   slow_be,
  input logic              slow_ready,
  input logic              fast_en,
  input logic              fast_we,
  input logic [DATA_W-1:0] fast_wdata,
  input logic [BE_W-1:0]   fast_be
);

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !cpu_ack && !slow_req);

  assert_mirror_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en && fast_we |=> slow_req && slow_we &&
      slow_wdata == $past(fast_wdata) && slow_be == $past(fast_be));

  assert_ack_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slow_req && slow_ready |=> cpu_ack && !slow_req);

  assert_fast_read_no_slow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en && !fast_we |=> !slow_req ##1 (cpu_ack && !slow_req));

  assert_ports_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slow_req |-> !fast_en);

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !cpu_ack);

  assert_slow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slow_req && !slow_ready |=> slow_req && $stable(slow_we) && $stable(slow_addr) &&
      $stable(slow_wdata) && $stable(slow_be));

endmodule

bind shadow_wt_ctrl shadow_wt_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .slow_req(slow_req), .slow_we(slow_we),
  .slow_addr(slow_addr), .slow_wdata(slow_wdata), .slow_be(slow_be), .slow_ready(slow_ready),
  .fast_en(fast_en), .fast_we(fast_we), .fast_wdata(fast_wdata), .fast_be(fast_be)
);

// File: tb/shadow_wt_ctrl_tb.sv
module shadow_wt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18, DW = 16, BW = 2, FAW = 16;
  localparam int BASE = 'h10000, SIZE = 'h10000;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [BW-1:0] cpu_be = '0;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic slow_req, slow_we;
  logic [AW-1:0] slow_addr;
  logic [DW-1:0] slow_wdata;
  logic [BW-1:0] slow_be;
  logic slow_ready = 0;
  logic [DW-1:0] slow_rdata = '0;
  logic fast_en, fast_we;
  logic [FAW-1:0] fast_addr;
  logic [DW-1:0] fast_wdata;
  logic [BW-1:0] fast_be;
  logic [DW-1:0] fast_rdata = '0;

  int checks = 0, errors = 0;
  logic [DW-1:0] slow_mem [int];
  logic [DW-1:0] fast_mem [int];
  logic [DW-1:0] gold [int];
  int wait_left = 0;

  shadow_wt_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) dut_i (.*);

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] rd(ref logic [DW-1:0] m [int], input int a);
    return m.exists(a) ? m[a] : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // fast RAM: one cycle read latency
  always @(posedge clk) if (fast_en) begin
    if (fast_we) fast_mem[int'(fast_addr)] = merge(rd(fast_mem, int'(fast_addr)), fast_wdata, fast_be);
    else fast_rdata <= rd(fast_mem, int'(fast_addr));
  end

  // slow memory with random wait states, driven just after the edge
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      slow_ready = 0;
    end else if (slow_ready) begin
      slow_ready = 0;
    end else if (slow_req) begin
      if (wait_left == 0) begin
        slow_ready = 1;
        slow_rdata = rd(slow_mem, int'(slow_addr));
        if (slow_we) slow_mem[int'(slow_addr)] = merge(rd(slow_mem, int'(slow_addr)), slow_wdata, slow_be);
        wait_left = $urandom_range(0, 4);
      end else begin
        wait_left--;
      end
    end
  end

  task automatic access(input bit we, input int a, input logic [DW-1:0] d, input logic [BW-1:0] be);
    bit win = (a >= BASE) && (a < BASE + SIZE);
    int n = 0, rdy_at = -1;
    logic [DW-1:0] exp = rd(gold, a);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d; cpu_be = be;
    #1;
    chk(fast_en == win, "R8 window decode", fast_en, win);
    if (win) begin
      chk(fast_we == we && int'(fast_addr) == a - BASE, "R2 fast port in accept cycle", fast_addr, a - BASE);
      if (we) chk(fast_wdata == d && fast_be == be, "R2 fast data/strobes", {fast_wdata, fast_be}, {d, be});
    end
    forever begin
      @(negedge clk);
      n++;
      if (n > 60) begin chk(0, "R4 watchdog", n, 0); break; end
      if (!win) chk(!fast_en, "R6 no fast access outside", fast_en, 0);
      if (win && !we) chk(!slow_req, "R5 no slow access on window read", slow_req, 0);
      if (slow_req) chk(slow_we == we && int'(slow_addr) == a && (!we || (slow_wdata == d && slow_be == be)),
                        "R3 slow port fields", {slow_we, slow_addr, slow_wdata, slow_be}, {we, AW'(a), d, be});
      if (cpu_ack) begin
        if (win && !we) chk(n == 2, "R5 read latency", n, 2);
        else chk(rdy_at >= 0 && n == rdy_at + 1, "R4 ack after slow ready", n, rdy_at + 1);
        if (!we) chk(cpu_rdata == exp, "R9 read returns last write", cpu_rdata, exp);
        cpu_req = 0;
        @(negedge clk);
        chk(!cpu_ack, "R7 ack is a single pulse", cpu_ack, 0);
        break;
      end
      if (slow_req && slow_ready) rdy_at = n;
    end
    if (we) begin
      gold[a] = merge(exp, d, be);
      chk(rd(slow_mem, a) == gold[a], "R3 slow copy holds written data", rd(slow_mem, a), gold[a]);
    end
  endtask

  initial begin
    int addrs [8] = '{BASE - 1, BASE, BASE + 1, BASE + 7, BASE + SIZE - 1, BASE + SIZE, 5, BASE + 'h1234};
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!cpu_ack && !slow_req && !fast_en, "R1 reset state", {cpu_ack, slow_req, fast_en}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!cpu_ack && !slow_req, "R1 first cycle after reset", {cpu_ack, slow_req}, 0);
        access(1, BASE, 16'hA55A, 2'b11);
        access(0, BASE, 0, 0);
        access(1, BASE, 16'h00FF, 2'b01);
        access(0, BASE, 0, 0);
        access(1, BASE + SIZE - 1, 16'h1357, 2'b10);
        access(0, BASE + SIZE - 1, 0, 0);
        access(1, BASE - 1, 16'hBEEF, 2'b11);
        access(0, BASE - 1, 0, 0);
        access(1, BASE + SIZE, 16'hCAFE, 2'b11);
        access(0, BASE + SIZE, 0, 0);
        for (int i = 0; i < 400; i++)
          access($urandom_range(0, 1), addrs[$urandom_range(0, 7)], DW'($urandom), BW'($urandom));
        foreach (addrs[i]) access(0, addrs[i], 0, 0);
      end
      begin
        repeat (150000) @(posedge clk);
        chk(0, "R4 watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule